// File: doc/BRIEF.md
# Two-Error Binary BCH Block Decoder

This block corrects up to two bit errors in each received word of a binary BCH code of length n = 2^m − 1 with m·2 parity bits (by default n = 31, k = 21, m = 5). A whole received word arrives on one bus in a single cycle. The odd syndromes are formed by XOR trees. A closed-form locator that needs no field inversion is built from them. Every bit position is then tested for a root in the same cycle, and the located bits are inverted. The decoder accepts a new word on every cycle and never stalls.

The word is captured together with its syndromes in a first register rank. Locator construction, root search and correction run between that rank and the output rank. The result appears two cycles after the input, with a flag that marks words the decoder could not resolve. The code is systematic, so the information bits are also presented on their own output.

Top module: `bch2_decoder`

## Requirements
- R1: Bit i of a block is the coefficient of x^i. The parity bits occupy positions 0 to n−k−1 and the information bits occupy positions n−k to n−1. The information output equals out_block[n−1:n−k], with out_info[0] taken from position n−k. The field is built on the primitive polynomial x^5 + x^2 + 1.
- R2: A valid codeword is returned unchanged with out_fail low.
- R3: A codeword with one inverted bit, at any position from 0 to n−1, is returned corrected with out_fail low.
- R4: A codeword with two inverted bits at any two distinct positions is returned corrected with out_fail low.
- R5: A received word whose first syndrome S1 is zero while S3 is non-zero raises out_fail and is returned with no bit changed.
- R6: For any received word, one of two outcomes holds. Either out_fail is high and the word is returned unmodified, or out_fail is low and the output is a valid codeword that differs from the received word in at most two positions.
- R7: out_valid equals in_valid delayed by exactly two clock cycles. Back-to-back valid words are each decoded, with no gap inserted.
- R8: While rst_n is low, out_valid, out_fail and out_block are all zero.
- R9: When no valid word reaches the output rank, out_block, out_info and out_fail hold their previous values, whatever is on in_block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies in_block in this cycle |
| in_block | input | N | Received word, bit i = coefficient of x^i |
| out_valid | output | 1 | Qualifies the output word, two cycles after in_valid |
| out_block | output | N | Corrected word, or the received word when out_fail is high |
| out_info | output | K | Information bits of out_block |
| out_fail | output | 1 | Word could not be decoded within two errors |

## Verification
The only state in the block is two ranks of registers, each holding one word together with its syndromes or its result. A corrupted syndrome or locator term therefore shows up on exactly one output word, two cycles after that word entered. It appears as a wrong bit flip, a missing correction or a spurious out_fail, and it never leaks into the next word. The stimulus streams codewords back to back with errors placed at both ends of the word and across the boundary between parity and information bits. A mistake in one root constant or one syndrome tap therefore shows up on a specific vector. A valid pipeline that slips by one cycle makes every streamed result land one slot off, which the checks catch at once.

// File: rtl/bch2_pkg.sv
package bch2_pkg;

   localparam int GF_W = 16;
   typedef logic [GF_W-1:0] gf_t;

   typedef enum logic [1:0] {
      ROOTS_NONE = 2'd0,
      ROOTS_ONE  = 2'd1,
      ROOTS_TWO  = 2'd2
   } root_cnt_e;

   // Polynomial-basis product in GF(2^m), reduction by poly (bit m set).
   function automatic gf_t gf_mul(input gf_t a, input gf_t b, input int m,
                                  input logic [GF_W:0] poly);
      gf_t acc;
      gf_t sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < GF_W; i++) begin
         if (i < m) begin
            if ((b & (gf_t'(1) << i)) != '0) acc ^= sh;
            sh = {sh[GF_W-2:0], 1'b0};
            if ((sh & (gf_t'(1) << m)) != '0) sh ^= poly[GF_W-1:0];
         end
      end
      return acc;
   endfunction

   // alpha^e, alpha being the class of x; used for constants only.
   function automatic gf_t gf_alpha_pow(input int e, input int m,
                                        input logic [GF_W:0] poly);
      gf_t r;
      r = gf_t'(1);
      for (int i = 0; i < e; i++) begin
         r = {r[GF_W-2:0], 1'b0};
         if ((r & (gf_t'(1) << m)) != '0) r ^= poly[GF_W-1:0];
      end
      return r;
   endfunction

endpackage

// File: rtl/bch2_syndrome.sv
module bch2_syndrome #(
   parameter int         M    = 5,
   parameter int         NUM  = 2,
   parameter logic [M:0] PRIM = 6'b100101,
   localparam int        N    = (1 << M) - 1
) (
   input  logic [N-1:0]          blk,
   output logic [NUM-1:0][M-1:0] syn
);

   // Taps of syndrome bit b for power pw: positions i where alpha^(pw*i) has bit b set.
   function automatic logic [N-1:0] tap_mask(input int pw, input int b);
      logic [N-1:0]   msk;
      bch2_pkg::gf_t  e;
      logic           hit;
      msk = '0;
      for (int i = 0; i < N; i++) begin
         e   = bch2_pkg::gf_alpha_pow((pw * i) % N, M, 17'(PRIM));
         hit = (e & (bch2_pkg::gf_t'(1) << b)) != '0;
         msk |= {{(N-1){1'b0}}, hit} << i;
      end
      return msk;
   endfunction

   // Odd syndromes S1, S3, ... : the j-th tree uses power 2j+1.
   for (genvar j = 0; j < NUM; j++) begin : g_syn
      for (genvar b = 0; b < M; b++) begin : g_bit
         localparam logic [N-1:0] TAPS = tap_mask(2 * j + 1, b);
         assign syn[j][b] = ^(blk & TAPS);
      end
   end

endmodule

// File: rtl/bch2_keyeq.sv
module bch2_keyeq #(
   parameter int         M    = 5,
   parameter logic [M:0] PRIM = 6'b100101
) (
   input  logic [M-1:0]        s1,
   input  logic [M-1:0]        s3,
   output logic [M-1:0]        lam0,
   output logic [M-1:0]        lam1,
   output logic [M-1:0]        lam2,
   output bch2_pkg::root_cnt_e roots_exp,
   output logic                syn_bad
);

   bch2_pkg::gf_t sq;
   bch2_pkg::gf_t cube;

   assign sq   = bch2_pkg::gf_mul(16'(s1), 16'(s1), M, 17'(PRIM));
   assign cube = bch2_pkg::gf_mul(sq, 16'(s1), M, 17'(PRIM));

   // Scaled locator: S1 + S1^2 x + (S3 + S1^3) x^2, identity when S1 = 0.
   always_comb begin
      if (s1 == '0) begin
         lam0      = {{(M-1){1'b0}}, 1'b1};
         lam1      = '0;
         lam2      = '0;
         roots_exp = bch2_pkg::ROOTS_NONE;
         syn_bad   = (s3 != '0);
      end else begin
         lam0      = s1;
         lam1      = sq[M-1:0];
         lam2      = s3 ^ cube[M-1:0];
         roots_exp = (lam2 == '0) ? bch2_pkg::ROOTS_ONE : bch2_pkg::ROOTS_TWO;
         syn_bad   = 1'b0;
      end
   end

endmodule

// File: rtl/bch2_chien.sv
module bch2_chien #(
   parameter int         M    = 5,
   parameter logic [M:0] PRIM = 6'b100101,
   localparam int        N    = (1 << M) - 1,
   localparam int        CW   = $clog2(N + 1)
) (
   input  logic [M-1:0]  lam0,
   input  logic [M-1:0]  lam1,
   input  logic [M-1:0]  lam2,
   output logic [N-1:0]  hits,
   output logic [CW-1:0] n_roots
);

   // Position i is in error when the locator vanishes at alpha^(-i).
   for (genvar i = 0; i < N; i++) begin : g_pos
      localparam bch2_pkg::gf_t B1 =
         bch2_pkg::gf_alpha_pow((N - i) % N, M, 17'(PRIM));
      localparam bch2_pkg::gf_t B2 =
         bch2_pkg::gf_alpha_pow((2 * (N - i)) % N, M, 17'(PRIM));
      bch2_pkg::gf_t t1;
      bch2_pkg::gf_t t2;
      assign t1      = bch2_pkg::gf_mul(16'(lam1), B1, M, 17'(PRIM));
      assign t2      = bch2_pkg::gf_mul(16'(lam2), B2, M, 17'(PRIM));
      assign hits[i] = ((lam0 ^ t1[M-1:0] ^ t2[M-1:0]) == '0);
   end

   assign n_roots = CW'($countones(hits));

   // A locator of degree <= 2 with non-zero constant term has at most two roots.
   always_comb begin
      if (lam0 != '0) begin
         p_root_bound_r6: assert ($countones(hits) <= 2)
            else $error("locator with more than two roots");
      end
      if (lam1 == '0 && lam2 == '0 && lam0 != '0) begin
         p_identity_no_root_r2: assert (hits == '0)
            else $error("constant locator produced a root");
      end
   end

endmodule

// File: rtl/bch2_decoder.sv
module bch2_decoder #(
   parameter int         M    = 5,
   parameter logic [M:0] PRIM = 6'b100101,
   localparam int        N    = (1 << M) - 1,
   localparam int        T    = 2,
   localparam int        K    = N - M * T,
   localparam int        CW   = $clog2(N + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [N-1:0] in_block,
   output logic         out_valid,
   output logic [N-1:0] out_block,
   output logic [K-1:0] out_info,
   output logic         out_fail
);

   if (M < 3 || M > 12) begin : g_bad_m
      $error("bch2_decoder: M must lie in 3..12");
   end
   if (PRIM[M] != 1'b1 || PRIM[0] != 1'b1) begin : g_bad_prim
      $error("bch2_decoder: PRIM must have degree M and a constant term");
   end

   // ---------------- syndrome trees on the incoming word ----------------
   logic [T-1:0][M-1:0] syn;

   bch2_syndrome #(.M(M), .NUM(T), .PRIM(PRIM)) u_syn (
      .blk (in_block),
      .syn (syn)
   );

   // ---------------- rank 1: word + syndromes ----------------
   logic         v1_q;
   logic [N-1:0] blk1_q;
   logic [M-1:0] s1_q;
   logic [M-1:0] s3_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q   <= 1'b0;
         blk1_q <= '0;
         s1_q   <= '0;
         s3_q   <= '0;
      end else begin
         v1_q <= in_valid;
         if (in_valid) begin
            blk1_q <= in_block;
            s1_q   <= syn[0];
            s3_q   <= syn[1];
         end
      end
   end

   // ---------------- locator, root search, correction ----------------
   logic [M-1:0]        lam0, lam1, lam2;
   bch2_pkg::root_cnt_e roots_exp;
   logic                syn_bad;
   logic [N-1:0]        hits;
   logic [CW-1:0]       n_roots;
   logic                dec_fail;
   logic [N-1:0]        fixed_blk;

   bch2_keyeq #(.M(M), .PRIM(PRIM)) u_keyeq (
      .s1        (s1_q),
      .s3        (s3_q),
      .lam0      (lam0),
      .lam1      (lam1),
      .lam2      (lam2),
      .roots_exp (roots_exp),
      .syn_bad   (syn_bad)
   );

   bch2_chien #(.M(M), .PRIM(PRIM)) u_chien (
      .lam0    (lam0),
      .lam1    (lam1),
      .lam2    (lam2),
      .hits    (hits),
      .n_roots (n_roots)
   );

   assign dec_fail  = syn_bad || (n_roots != CW'(roots_exp));
   assign fixed_blk = dec_fail ? blk1_q : (blk1_q ^ hits);

   // ---------------- rank 2: output ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_block <= '0;
         out_fail  <= 1'b0;
      end else begin
         out_valid <= v1_q;
         if (v1_q) begin
            out_block <= fixed_blk;
            out_fail  <= dec_fail;
         end
      end
   end

   assign out_info = out_block[N-1:N-K];

   // ---------------- assertions ----------------
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= 2'd0;
      else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
   end

   p_valid_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)))
      else $error("out_valid is not in_valid delayed by two");

   p_clean_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (v1_q && s1_q == '0 && s3_q == '0) |=> (out_block == $past(blk1_q) && !out_fail))
      else $error("zero-syndrome word altered");

   p_fail_unmodified_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fail) |-> (out_block == $past(blk1_q)))
      else $error("failed word was modified");

   p_flip_weight_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_fail) |-> ($countones(out_block ^ $past(blk1_q)) <= 2))
      else $error("more than two bits changed");

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !v1_q |=> ($stable(out_block) && $stable(out_fail)))
      else $error("output changed without a valid word");

endmodule

// File: tb/test_bch2_decoder.sv
`timescale 1ns/1ps
module test_bch2_decoder;

   localparam int N = 31;
   localparam int K = 21;
   localparam int P = N - K;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [N-1:0] in_block;
   logic         out_valid;
   logic [N-1:0] out_block;
   logic [K-1:0] out_info;
   logic         out_fail;

   bch2_decoder i_bch2_decoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_block  (in_block),
      .out_valid (out_valid),
      .out_block (out_block),
      .out_info  (out_info),
      .out_fail  (out_fail)
   );

   always #4 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------- bench-side field and code arithmetic ----------
   function automatic logic [4:0] b_mul(input logic [4:0] a, input logic [4:0] b);
      logic [4:0] p, x, y;
      p = '0; x = a; y = b;
      for (int k = 0; k < 5; k++) begin
         if (y[0]) p ^= x;
         y = y >> 1;
         x = {x[3:0], 1'b0} ^ (x[4] ? 5'b00101 : 5'b00000);
      end
      return p;
   endfunction

   function automatic logic [4:0] b_alpha(input int e);
      logic [4:0] r;
      r = 5'd1;
      for (int k = 0; k < e; k++) r = b_mul(r, 5'b00010);
      return r;
   endfunction

   logic [P:0] gpoly;

   task automatic build_gen();
      logic [4:0] c [0:P];
      int exps [10] = '{1, 2, 4, 8, 16, 3, 6, 12, 24, 17};
      int deg;
      logic [4:0] beta;
      for (int d = 0; d <= P; d++) c[d] = '0;
      c[0] = 5'd1;
      deg  = 0;
      for (int r = 0; r < 10; r++) begin
         beta = b_alpha(exps[r]);
         for (int d = deg + 1; d >= 1; d--) c[d] = c[d-1] ^ b_mul(c[d], beta);
         c[0] = b_mul(c[0], beta);
         deg++;
      end
      for (int d = 0; d <= P; d++) gpoly[d] = c[d][0];
   endtask

   function automatic logic [P-1:0] b_rem(input logic [N-1:0] v);
      logic [N-1:0] w;
      w = v;
      for (int i = N - 1; i >= P; i--)
         if (w[i]) w ^= N'(gpoly) << (i - P);
      return w[P-1:0];
   endfunction

   function automatic logic [N-1:0] encode(input logic [K-1:0] info);
      return {info, b_rem({info, {P{1'b0}}})};
   endfunction

   // ---------- streamed vector table ----------
   typedef struct packed {
      logic [K-1:0] info;
      logic [1:0]   nerr;
      logic [4:0]   pa;
      logic [4:0]   pb;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{21'h000000, 2'd0, 5'd0,  5'd0 },   // R2 all-zero codeword
      '{21'h1FFFFF, 2'd0, 5'd0,  5'd0 },   // R2
      '{21'h0A5A5A, 2'd1, 5'd0,  5'd0 },   // R3 first position
      '{21'h13C3C3, 2'd1, 5'd30, 5'd0 },   // R3 last position
      '{21'h155555, 2'd1, 5'd10, 5'd0 },   // R3 first info bit
      '{21'h0F0F0F, 2'd1, 5'd9,  5'd0 },   // R3 last parity bit
      '{21'h1ABCDE, 2'd2, 5'd0,  5'd30},   // R4 both ends
      '{21'h012345, 2'd2, 5'd14, 5'd15},   // R4 adjacent
      '{21'h1FFFFF, 2'd2, 5'd3,  5'd27},   // R4
      '{21'h000000, 2'd2, 5'd9,  5'd10},   // R4 across parity/info edge
      '{21'h0DEAD1, 2'd1, 5'd21, 5'd0 },   // R3
      '{21'h13579B, 2'd2, 5'd5,  5'd20}    // R4
   };

   logic [N-1:0] exp_blk [NV];
   logic [N-1:0] rx_blk  [NV];

   localparam int NB = 5;
   localparam logic [N-1:0] BAD_ERR [NB] = '{
      31'h00000007, 31'h40020004, 31'h10101010, 31'h00F00000, 31'h48000201
   };

   logic [N-1:0] r5_blk;
   logic [N-1:0] cw;
   logic [N-1:0] emask;
   int           cpos;

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_block = '0;
      build_gen();

      repeat (3) @(negedge clk);
      // R8: reset values
      chk(out_valid == 1'b0 && out_fail == 1'b0, "R8 reset valid/fail",
          {30'd0, out_valid, out_fail}, 32'd0);
      chk(out_block == '0, "R8 reset block", 32'(out_block), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // sanity: generator gives codewords
      chk(b_rem(encode(21'h0ABCDE)) == '0, "R1 encoder sanity",
          32'(b_rem(encode(21'h0ABCDE))), 32'd0);

      for (int j = 0; j < NV; j++) begin
         exp_blk[j] = encode(VECS[j].info);
         emask = '0;
         if (VECS[j].nerr >= 2'd1) emask |= N'(1) << VECS[j].pa;
         if (VECS[j].nerr == 2'd2) emask |= N'(1) << VECS[j].pb;
         rx_blk[j] = exp_blk[j] ^ emask;
      end

      // ---------- back-to-back stream (R1..R4, R7) ----------
      for (int t = 0; t < NV + 2; t++) begin
         if (t >= 2) begin
            chk(out_valid == 1'b1 && out_fail == 1'b0 && out_block == exp_blk[t-2],
                $sformatf("R7/R2/R3/R4 vec%0d block", t - 2),
                {out_valid, out_block}, {1'b1, exp_blk[t-2]});
            chk(out_info == VECS[t-2].info, $sformatf("R1 vec%0d info", t - 2),
                32'(out_info), 32'(VECS[t-2].info));
         end
         if (t < NV) begin
            in_valid = 1'b1;
            in_block = rx_blk[t];
         end else begin
            in_valid = 1'b0;
            in_block = '0;
         end
         @(negedge clk);
      end

      // ---------- R7: gaps in the valid stream ----------
      begin
         bit pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
         for (int u = 0; u < 7; u++) begin
            if (u >= 2)
               chk(out_valid == pat[u-2], $sformatf("R7 gap slot%0d", u - 2),
                   32'(out_valid), 32'(pat[u-2]));
            in_valid = (u < 5) ? pat[u] : 1'b0;
            in_block = encode(21'h00F00F);
            @(negedge clk);
         end
      end

      // ---------- R5: S1 = 0, S3 != 0 ----------
      cpos = 0;
      for (int e = 2; e < N; e++) if (b_alpha(e) == 5'b00011) cpos = e;
      cw     = encode(21'h123456);
      r5_blk = cw ^ 31'h3 ^ (N'(1) << cpos);
      in_valid = 1'b1;
      in_block = r5_blk;
      @(negedge clk);
      in_valid = 1'b0;
      in_block = ~r5_blk;
      @(negedge clk);
      chk(out_valid == 1'b1 && out_fail == 1'b1, "R5 fail flag",
          {30'd0, out_valid, out_fail}, 32'd3);
      chk(out_block == r5_blk, "R5 block unmodified", 32'(out_block), 32'(r5_blk));

      // ---------- R9: outputs hold while idle ----------
      for (int h = 0; h < 3; h++) begin
         in_valid = 1'b0;
         in_block = 31'h5A5A5A5A ^ N'(h);
         @(negedge clk);
         chk(out_valid == 1'b0 && out_fail == 1'b1 && out_block == r5_blk &&
             out_info == r5_blk[N-1:P],
             $sformatf("R9 hold cycle%0d", h), 32'(out_block), 32'(r5_blk));
      end

      // ---------- R6: beyond two errors ----------
      for (int b = 0; b < NB; b++) begin
         logic [N-1:0] rx;
         rx = encode(21'h0C0FFE ^ K'(b * 77)) ^ BAD_ERR[b];
         in_valid = 1'b1;
         in_block = rx;
         @(negedge clk);
         in_valid = 1'b0;
         @(negedge clk);
         if (out_fail)
            chk(out_valid && out_block == rx, $sformatf("R6 pattern%0d passthrough", b),
                32'(out_block), 32'(rx));
         else
            chk(out_valid && $countones(out_block ^ rx) <= 2 && b_rem(out_block) == '0,
                $sformatf("R6 pattern%0d miscorrection bound", b),
                32'($countones(out_block ^ rx)), 32'd2);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule